// File: doc/BRIEF.md
# Two-Sided Mailbox Register File

This block is a byte-wide mailbox shared by a host and a management controller. Each side has its own register port, made of an address, a write strobe, write data and a registered read-data output. Both ports see the same 24-offset map. It holds sixteen message bytes, a 16-bit sticky status word split over two bytes, one control register per side, and a 16-bit interrupt enable word per side. Each side has one interrupt output.

The controller delivers a message by writing data bytes. Each such write marks the matching status bit, and that bit stays set until some side writes a one to it. Each side picks, through its own enable word, which status bits assert its interrupt. Either side can also "ping" the other through its own control register. The ping latches an interrupt flag in the peer's control register, and the peer's mask bit decides whether that flag reaches the peer's interrupt line.

The block has no state machine. All state is plain registers, updated on the clock edge at which the write strobe is sampled.

Top module: `mbx_regfile`

## Requirements
- R1: A write from either port to offset n (0x00..0x0F) stores the byte in data slot n. Read data is registered: it shows the contents of the addressed register as they were at the clock edge that samples the address, so a value written at one edge is read back one edge later.
- R2: A controller write to data offset n sets status bit n and leaves every other status bit unchanged. Status bits 7..0 read at 0x10 and bits 15..8 read at 0x11. For example, offset 0x0D sets 0x11 bit 5 and offset 0x0F sets 0x11 bit 7. Host writes to data offsets set no status bit.
- R3: Writing 0x10 or 0x11 from either port clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If a status bit is set by a controller data write and cleared by a write in the same cycle, the bit ends up set.
- R5: When both ports write the same data offset in the same cycle, the controller's byte is stored.
- R6: The controller control register is at 0x12 and the host control register is at 0x13. Bit 1 (mask) stores the written value and bit 0 always reads 0. A write with bits 1:0 = 11 sets bit 7 (ping flag) of the other side's control register. Writing 1 to bit 7 of one's own control register clears that flag, and a simultaneous ping wins.
- R7: The host interrupt is high when (status & host enable word) is non-zero or when the host ping flag is set with the host mask clear. The host enable word is at 0x16 (bits 7..0) and 0x17 (bits 15..8). The controller interrupt follows the same rule with its enable word at 0x14/0x15 and its register at 0x12. Both interrupts change right after the edge that updates the registers.
- R8: Only the controller may write 0x12, 0x14 and 0x15, and only the host may write 0x13, 0x16 and 0x17. A write from the other port to these offsets is ignored.
- R9: Offsets 0x18..0x1F read 0x00, and writes to them change nothing.
- R10: During reset every register, both read outputs and both interrupts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 5 | Host register offset |
| h_we | input | 1 | Host write strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (registered) |
| c_addr | input | 5 | Controller register offset |
| c_we | input | 1 | Controller write strobe |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data (registered) |
| h_irq | output | 1 | Interrupt to the host |
| c_irq | output | 1 | Interrupt to the controller |

## Verification
The data path is tried with single-port writes read back through the other port, and with a sweep of all sixteen slots from the host. The sweep shows that host writes leave the status bits alone. Controller writes to a low slot, to slot 13 and to slot 15 show that each slot sets its own status bit. Colliding patterns put two writes in one cycle: a clear against a set, and both ports on one data slot. These show which side wins. Ping sequences are run with the peer mask both set and clear, and writes to the other side's registers are sent from the wrong port. Together they separate the flag from the mask and the owner's access from a foreign one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int NUM_DATA = 16;
    localparam int STAT_W   = 2 * BYTE_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam addr_t OFF_STAT_LO = 5'h10;
    localparam addr_t OFF_STAT_HI = 5'h11;
    localparam addr_t OFF_CCTL    = 5'h12;
    localparam addr_t OFF_HCTL    = 5'h13;
    localparam addr_t OFF_CEN_LO  = 5'h14;
    localparam addr_t OFF_CEN_HI  = 5'h15;
    localparam addr_t OFF_HEN_LO  = 5'h16;
    localparam addr_t OFF_HEN_HI  = 5'h17;

    localparam int CTL_FLAG_BIT = 7;
    localparam int CTL_MASK_BIT = 1;
    localparam int CTL_PING_BIT = 0;
endpackage

// File: rtl/mbx_data.sv
module mbx_data #(
    parameter int NUM = 16,
    parameter int W   = 8,
    parameter int AW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_we,
    input  logic [AW-1:0]  h_addr,
    input  logic [W-1:0]   h_wdata,
    input  logic           c_we,
    input  logic [AW-1:0]  c_addr,
    input  logic [W-1:0]   c_wdata,
    output logic [NUM*W-1:0] slots,
    output logic [NUM-1:0] c_hit
);
    logic [NUM-1:0] h_hit;

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        assign h_hit[g] = h_we && (h_addr == AW'(g));
        assign c_hit[g] = c_we && (c_addr == AW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[g*W +: W] <= '0;
            end else if (c_hit[g]) begin
                slots[g*W +: W] <= c_wdata;
            end else if (h_hit[g]) begin
                slots[g*W +: W] <= h_wdata;
            end
        end

        // R5: controller byte wins a same-slot collision
        p_ctrl_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (c_hit[g] && h_hit[g]) |=> (slots[g*W +: W] == $past(c_wdata)));
    end
endmodule

// File: rtl/mbx_status.sv
module mbx_status #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_vec,
    input  logic [SW-1:0] clr_vec,
    output logic [SW-1:0] st
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            st <= (st & ~clr_vec) | set_vec;
        end
    end

    // R4: a set event always lands, even against a clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((st & $past(set_vec)) == $past(set_vec)));

    // R3: bits cleared without a set go low
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_vec) |=> ((st & $past(clr_vec & ~set_vec)) == '0));

    // R2: bits not cleared are sticky
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st & $past(st & ~clr_vec)) == $past(st & ~clr_vec)));
endmodule

// File: rtl/mbx_side.sv
module mbx_side
    import mbx_pkg::*;
#(
    parameter int    W       = 8,
    parameter int    AW      = 5,
    parameter addr_t CTL_OFF = 5'h13,
    parameter addr_t EN_LO   = 5'h16,
    parameter addr_t EN_HI   = 5'h17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [W-1:0]   wdata,
    input  logic           peer_ping,
    input  logic [2*W-1:0] status,
    output logic           ping_out,
    output logic [W-1:0]   ctl_rd,
    output logic [2*W-1:0] en,
    output logic           irq
);
    logic flag_q;
    logic mask_q;
    logic wr_ctl;
    logic unused_wbits;

    assign wr_ctl       = we && (addr == CTL_OFF);
    assign ping_out     = wr_ctl && wdata[CTL_MASK_BIT] && wdata[CTL_PING_BIT];
    assign unused_wbits = ^wdata[W-2:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (peer_ping) begin
            flag_q <= 1'b1;
        end else if (wr_ctl && wdata[CTL_FLAG_BIT]) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else if (wr_ctl) begin
            mask_q <= wdata[CTL_MASK_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= '0;
        end else if (we) begin
            if (addr == EN_LO) en[W-1:0]   <= wdata;
            if (addr == EN_HI) en[2*W-1:W] <= wdata;
        end
    end

    assign ctl_rd = {flag_q, {(W-3){1'b0}}, mask_q, 1'b0};
    assign irq    = (|(status & en)) | (flag_q & ~mask_q);

    // R6: a ping from the peer always latches the flag
    p_ping_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        peer_ping |=> ctl_rd[CTL_FLAG_BIT]);

    // R7: an unmasked ping reaches the interrupt line
    p_ping_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_ping && !mask_q && !wr_ctl) |=> irq);

    // R6: bit 0 never reads back as one
    p_ping_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd[CTL_PING_BIT] == 1'b0);
endmodule

// File: rtl/mbx_rdport.sv
module mbx_rdport
    import mbx_pkg::*;
#(
    parameter int NUM = 16,
    parameter int W   = 8,
    parameter int AW  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [NUM*W-1:0] slots,
    input  logic [2*W-1:0]   status,
    input  logic [W-1:0]     cctl,
    input  logic [W-1:0]     hctl,
    input  logic [2*W-1:0]   cen,
    input  logic [2*W-1:0]   hen,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] sel;

    always_comb begin
        sel = '0;
        if (int'(addr) < NUM) begin
            sel = slots[int'(addr)*W +: W];
        end else begin
            case (addr)
                OFF_STAT_LO: sel = status[W-1:0];
                OFF_STAT_HI: sel = status[2*W-1:W];
                OFF_CCTL:    sel = cctl;
                OFF_HCTL:    sel = hctl;
                OFF_CEN_LO:  sel = cen[W-1:0];
                OFF_CEN_HI:  sel = cen[2*W-1:W];
                OFF_HEN_LO:  sel = hen[W-1:0];
                OFF_HEN_HI:  sel = hen[2*W-1:W];
                default:     sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= sel;
        end
    end

    // R9: unmapped offsets read as zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) > int'(OFF_HEN_HI)) |=> (rdata == '0));

    // R10: read data is zero while in reset
    p_reset_rdata_r10: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0));
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] h_addr,
    input  logic       h_we,
    input  logic [7:0] h_wdata,
    output logic [7:0] h_rdata,
    input  logic [4:0] c_addr,
    input  logic       c_we,
    input  logic [7:0] c_wdata,
    output logic [7:0] c_rdata,
    output logic       h_irq,
    output logic       c_irq
);
    logic [NUM_DATA*BYTE_W-1:0] slots;
    logic [NUM_DATA-1:0]        c_hit;
    logic [STAT_W-1:0]          status;
    logic [STAT_W-1:0]          set_vec;
    logic [STAT_W-1:0]          clr_vec;
    logic [STAT_W-1:0]          h_clr;
    logic [STAT_W-1:0]          c_clr;
    logic [STAT_W-1:0]          cen;
    logic [STAT_W-1:0]          hen;
    byte_t                      cctl;
    byte_t                      hctl;
    logic                       h_ping;
    logic                       c_ping;
    logic                       h_we_own;
    logic                       c_we_own;

    // R8: each side's private registers accept only their owner's strobe
    assign h_we_own = h_we;
    assign c_we_own = c_we;

    mbx_data #(.NUM(NUM_DATA), .W(BYTE_W), .AW(ADDR_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (h_we),
        .h_addr  (h_addr),
        .h_wdata (h_wdata),
        .c_we    (c_we),
        .c_addr  (c_addr),
        .c_wdata (c_wdata),
        .slots   (slots),
        .c_hit   (c_hit)
    );

    always_comb begin
        h_clr = '0;
        c_clr = '0;
        if (h_we && h_addr == OFF_STAT_LO) h_clr[BYTE_W-1:0]      = h_wdata;
        if (h_we && h_addr == OFF_STAT_HI) h_clr[STAT_W-1:BYTE_W] = h_wdata;
        if (c_we && c_addr == OFF_STAT_LO) c_clr[BYTE_W-1:0]      = c_wdata;
        if (c_we && c_addr == OFF_STAT_HI) c_clr[STAT_W-1:BYTE_W] = c_wdata;
    end

    assign clr_vec = h_clr | c_clr;
    assign set_vec = STAT_W'(c_hit);

    mbx_status #(.SW(STAT_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .st      (status)
    );

    mbx_side #(.W(BYTE_W), .AW(ADDR_W), .CTL_OFF(OFF_HCTL),
               .EN_LO(OFF_HEN_LO), .EN_HI(OFF_HEN_HI)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (h_we_own),
        .addr      (h_addr),
        .wdata     (h_wdata),
        .peer_ping (c_ping),
        .status    (status),
        .ping_out  (h_ping),
        .ctl_rd    (hctl),
        .en        (hen),
        .irq       (h_irq)
    );

    mbx_side #(.W(BYTE_W), .AW(ADDR_W), .CTL_OFF(OFF_CCTL),
               .EN_LO(OFF_CEN_LO), .EN_HI(OFF_CEN_HI)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (c_we_own),
        .addr      (c_addr),
        .wdata     (c_wdata),
        .peer_ping (h_ping),
        .status    (status),
        .ping_out  (c_ping),
        .ctl_rd    (cctl),
        .en        (cen),
        .irq       (c_irq)
    );

    mbx_rdport #(.NUM(NUM_DATA), .W(BYTE_W), .AW(ADDR_W)) u_hrd (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (h_addr),
        .slots  (slots),
        .status (status),
        .cctl   (cctl),
        .hctl   (hctl),
        .cen    (cen),
        .hen    (hen),
        .rdata  (h_rdata)
    );

    mbx_rdport #(.NUM(NUM_DATA), .W(BYTE_W), .AW(ADDR_W)) u_crd (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (c_addr),
        .slots  (slots),
        .status (status),
        .cctl   (cctl),
        .hctl   (hctl),
        .cen    (cen),
        .hen    (hen),
        .rdata  (c_rdata)
    );

    // R8: host writes to controller-owned offsets leave them alone
    p_foreign_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && (h_addr == OFF_CEN_LO || h_addr == OFF_CEN_HI) && !c_we) |=> $stable(cen));

    p_foreign_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr == OFF_CCTL && !c_we) |=> $stable(cctl));

    // R10: interrupts stay low in reset
    p_reset_irq_r10: assert property (@(posedge clk)
        !rst_n |=> (!h_irq && !c_irq));
endmodule

// File: tb/mbx_regfile_test.sv
module mbx_regfile_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] h_addr = '0;
    logic       h_we = 1'b0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic [4:0] c_addr = '0;
    logic       c_we = 1'b0;
    logic [7:0] c_wdata = '0;
    logic [7:0] c_rdata;
    logic       h_irq;
    logic       c_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    due;
        int    kind;
        logic [7:0] exp;
        string tag;
    } item_t;

    item_t q[$];

    mbx_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_addr(c_addr), .c_we(c_we), .c_wdata(c_wdata), .c_rdata(c_rdata),
        .h_irq(h_irq), .c_irq(c_irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic drive(input logic hwe, input logic [4:0] ha, input logic [7:0] hd,
                         input logic cwe, input logic [4:0] ca, input logic [7:0] cd);
        @(negedge clk);
        h_we = hwe; h_addr = ha; h_wdata = hd;
        c_we = cwe; c_addr = ca; c_wdata = cd;
    endtask

    task automatic hw(input logic [4:0] a, input logic [7:0] d);
        drive(1'b1, a, d, 1'b0, 5'h00, 8'h00);
    endtask

    task automatic cw(input logic [4:0] a, input logic [7:0] d);
        drive(1'b0, 5'h00, 8'h00, 1'b1, a, d);
    endtask

    task automatic rd(input int side, input logic [4:0] a, input logic [7:0] e, input string tag);
        item_t it;
        if (side == 0) drive(1'b0, a, 8'h00, 1'b0, 5'h00, 8'h00);
        else           drive(1'b0, 5'h00, 8'h00, 1'b0, a, 8'h00);
        it.due = cyc + 1; it.kind = side; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic irqchk(input logic he, input logic ce, input string tag);
        item_t it;
        drive(1'b0, 5'h00, 8'h00, 1'b0, 5'h00, 8'h00);
        it.due = cyc + 1; it.kind = 2; it.exp = {6'b0, he, ce}; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: compares results as the design produces them
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.kind)
                    0:       act = h_rdata;
                    1:       act = c_rdata;
                    default: act = {6'b0, h_irq, c_irq};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(0, 5'h00, 8'h00, "R10 data0");
        rd(0, 5'h11, 8'h00, "R10 status hi");
        rd(0, 5'h13, 8'h00, "R10 host ctl");
        rd(1, 5'h12, 8'h00, "R10 ctrl ctl");
        rd(1, 5'h16, 8'h00, "R10 host en");
        irqchk(1'b0, 1'b0, "R10 irqs low");

        // R1 host write, read through both ports; R2 host sets no status
        hw(5'h03, 8'hA5);
        rd(1, 5'h03, 8'hA5, "R1 ctrl reads host byte");
        rd(0, 5'h03, 8'hA5, "R1 host reads own byte");
        rd(0, 5'h10, 8'h00, "R2 host write no status lo");
        rd(0, 5'h11, 8'h00, "R2 host write no status hi");

        // R2 controller writes set status bits
        cw(5'h02, 8'h5C);
        rd(0, 5'h02, 8'h5C, "R1 host reads ctrl byte");
        rd(1, 5'h10, 8'h04, "R2 slot2 sets bit2");
        cw(5'h0D, 8'h11);
        rd(0, 5'h11, 8'h20, "R2 slot13 response bit");
        cw(5'h0F, 8'h80);
        rd(0, 5'h11, 8'hA0, "R2 slot15 attention bit");
        rd(0, 5'h0F, 8'h80, "R1 flag byte");

        // R7 host enable gates status
        irqchk(1'b0, 1'b0, "R7 no enables no irq");
        hw(5'h17, 8'h80);
        irqchk(1'b1, 1'b0, "R7 attention enabled");

        // R3 write-one-to-clear
        hw(5'h11, 8'h80);
        rd(0, 5'h11, 8'h20, "R3 clear attention only");
        irqchk(1'b0, 1'b0, "R7 irq drops after clear");
        hw(5'h11, 8'h00);
        rd(0, 5'h11, 8'h20, "R3 zero write keeps");
        cw(5'h10, 8'h04);
        rd(1, 5'h10, 8'h00, "R3 ctrl clears lo");
        hw(5'h11, 8'h20);
        rd(0, 5'h11, 8'h00, "R3 host clears response");

        // R4 set against clear in one cycle
        drive(1'b1, 5'h11, 8'h20, 1'b1, 5'h0D, 8'h77);
        rd(0, 5'h11, 8'h20, "R4 set wins");
        rd(0, 5'h0D, 8'h77, "R4 data stored");

        // R5 same-slot collision
        drive(1'b1, 5'h05, 8'h11, 1'b1, 5'h05, 8'h22);
        rd(0, 5'h05, 8'h22, "R5 controller byte kept");
        rd(0, 5'h10, 8'h20, "R2 slot5 sets bit5");

        // R8 foreign writes ignored
        cw(5'h16, 8'hFF);
        rd(0, 5'h16, 8'h00, "R8 ctrl cannot write host en");
        hw(5'h14, 8'hFF);
        rd(1, 5'h14, 8'h00, "R8 host cannot write ctrl en");
        hw(5'h12, 8'h83);
        rd(1, 5'h12, 8'h00, "R8 host cannot write ctrl ctl");
        irqchk(1'b0, 1'b0, "R8 irqs unchanged");

        // R6 and R7 ping paths
        hw(5'h13, 8'h03);
        rd(1, 5'h12, 8'h80, "R6 host ping flags ctrl");
        rd(0, 5'h13, 8'h02, "R6 host mask stored ping reads 0");
        irqchk(1'b0, 1'b1, "R7 unmasked ping irq");
        cw(5'h12, 8'h02);
        rd(1, 5'h12, 8'h82, "R6 mask set flag kept");
        irqchk(1'b0, 1'b0, "R7 masked ping no irq");
        cw(5'h12, 8'h80);
        rd(1, 5'h12, 8'h00, "R6 owner clears flag");
        cw(5'h12, 8'h03);
        rd(0, 5'h13, 8'h82, "R6 ctrl ping flags host");
        irqchk(1'b0, 1'b0, "R7 host masked");
        hw(5'h13, 8'h00);
        irqchk(1'b1, 1'b0, "R7 host unmask raises irq");
        hw(5'h13, 8'h80);
        rd(0, 5'h13, 8'h00, "R6 host clears flag");
        irqchk(1'b0, 1'b0, "R7 host irq cleared");
        cw(5'h15, 8'h20);
        rd(1, 5'h15, 8'h20, "R7 ctrl enable stored");
        irqchk(1'b0, 1'b1, "R7 ctrl status irq");

        // R9 unmapped offsets
        rd(0, 5'h18, 8'h00, "R9 unmapped read");
        hw(5'h1A, 8'hFF);
        rd(0, 5'h1A, 8'h00, "R9 unmapped write ignored");
        rd(1, 5'h1F, 8'h00, "R9 top offset");

        // R1 sweep of all slots from host; R2 status untouched
        for (int i = 0; i < 16; i++) hw(5'(i), 8'(i * 16 + 15 - i));
        for (int i = 0; i < 16; i++) rd(1, 5'(i), 8'(i * 16 + 15 - i), "R1 sweep");
        rd(0, 5'h10, 8'h20, "R2 sweep no status lo");
        rd(0, 5'h11, 8'h20, "R2 sweep no status hi");

        drive(1'b0, 5'h00, 8'h00, 1'b0, 5'h00, 8'h00);
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule